// File: doc/BRIEF.md
# Synchronous FIFO USB Bridge Sequencer

This block sits on the FPGA side of a USB FIFO chip that runs in synchronous FIFO mode on a single clock shared with the chip, over an 8-bit bidirectional bus. It works in half-duplex, frame by frame. It reads one frame of `FRAME_BYTES` bytes from the host and hands the bytes to local processing logic over a valid/ready stream. It then takes one result frame of the same size from the local logic and writes it to the host. After that it goes back to waiting for the next host frame.

The chip reports with two active-low flags: one says the chip holds bytes for the FPGA, the other says it can accept bytes. The bridge drives three active-low strobes: output enable, read and write. The bus is split into an input, an output and an output-enable. The design sequences the strobes, counts the bytes of each frame and turns the bus around between phases. When a chip flag or the local consumer stalls partway through a frame, the bridge pauses and later resumes without losing or repeating a byte.

Top module: `usb_fifo_bridge`

## Requirements
- R1: After reset, `out_en_no`, `rd_stb_no` and `wr_stb_no` are high, `bus_oe_o` is low (bus released), `rx_valid_o` and `tx_ready_o` are low, and the block waits for receive data.
- R2: A read starts only while `rx_avail_ni` is low. `out_en_no` goes low first, and `rd_stb_no` goes low on a later clock, never on the same edge.
- R3: A byte is taken from `bus_i` only on a rising edge where `rx_avail_ni` and `rd_stb_no` are both low. Taken bytes appear on `rx_data_o`/`rx_valid_o` in arrival order, with none dropped or repeated.
- R4: The receive phase takes exactly `FRAME_BYTES` bytes. No write happens before the last of them is taken, and no read happens after it until the transmit phase is over.
- R5: `wr_stb_no` is low only while `bus_oe_o` is high. A byte is delivered on each edge where `wr_stb_no` and `tx_space_ni` are both low. The delivered bytes equal the accepted `tx_data_i` bytes, in order.
- R6: If `tx_space_ni` is high while `wr_stb_no` is low, `wr_stb_no` is high on the next cycle. The byte on `bus_o` then stays unchanged until it is written.
- R7: After exactly `FRAME_BYTES` bytes are written, the block releases the bus, sets `wr_stb_no` high, drops `tx_ready_o` and goes back to waiting for receive data.
- R8: If `rx_avail_ni` is high while `out_en_no` is low, both `out_en_no` and `rd_stb_no` are high on the next cycle. The frame byte count is kept, and the frame resumes with the OE-first sequence when `rx_avail_ni` falls again.
- R9: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_valid_o` and `rx_data_o` stay unchanged. Reads pause so that no byte is taken without a free buffer slot.
- R10: `bus_oe_o` is high only in the transmit phase, and never while `out_en_no` or `rd_stb_no` is low. At least one cycle with all strobes high and the bus released separates the read and write phases, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the FIFO chip |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_avail_ni | input | 1 | Low while the chip holds bytes for the FPGA |
| tx_space_ni | input | 1 | Low while the chip can accept bytes |
| out_en_no | output | 1 | Chip output enable strobe, active low |
| rd_stb_no | output | 1 | Read strobe, active low |
| wr_stb_no | output | 1 | Write strobe, active low |
| bus_i | input | DW (8) | Bus value read from the pads |
| bus_o | output | DW (8) | Bus value driven in the transmit phase |
| bus_oe_o | output | 1 | Pad driver enable; low means high impedance |
| rx_data_o | output | DW (8) | Received byte toward local logic |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Local consumer ready |
| tx_data_i | input | DW (8) | Result byte from local logic |
| tx_valid_i | input | 1 | Result byte valid |
| tx_ready_o | output | 1 | Bridge accepts a result byte |

## Verification
The bench builds the bridge with `FRAME_BYTES` = 16 and `RX_DEPTH` = 2. With short frames, five complete receive/transmit cycles finish in a few hundred clocks. The frame-end edges, both bus turnarounds, and the pauses that land on or near the last byte of a frame are hit many times. A depth of two keeps the read path at one byte per clock. The host-flag pauses, the write-flag pauses and consumer backpressure can then be laid over streaming reads and writes, and the tests show that frame counts and byte order survive each kind of stall.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
  typedef enum logic [2:0] {
    PH_RX_WAIT,
    PH_RX_RUN,
    PH_TURN_TX,
    PH_TX_RUN,
    PH_TURN_RX
  } phase_e;
endpackage

// File: rtl/ufb_counter.sv
module ufb_counter #(
  parameter int unsigned LIMIT = 4096,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ufb_rx_fifo.sv
module ufb_rx_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned DW = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          valid_o,
  output logic          room_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level, level_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // room_o refers to the level after this edge: a read issued now lands next edge
  always_comb begin
    level_nxt = level + LW'(push_i) - LW'(pop_i);
    room_o    = level_nxt < LW'(DEPTH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_i) wptr <= bump(wptr);
      if (pop_i)  rptr <= bump(rptr);
      level <= level_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr] <= din_i;
  end

  assign dout_o  = mem[rptr];
  assign valid_o = level != '0;
endmodule

// File: rtl/ufb_tx_hold.sv
module ufb_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic          valid_nxt_o,
  output logic [DW-1:0] dout_o
);
  assign valid_nxt_o = load_i | (valid_o & ~take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      valid_o <= valid_nxt_o;
      if (load_i) dout_o <= din_i;
    end
  end
endmodule

// File: rtl/ufb_ctrl.sv
module ufb_ctrl
  import ufb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rx_avail_ni,
  input  logic   tx_space_ni,
  input  logic   rx_room_i,
  input  logic   rx_last_i,
  input  logic   tx_last_i,
  input  logic   hold_valid_nxt_i,
  output phase_e phase_o,
  output logic   oe_no,
  output logic   rd_no,
  output logic   wr_no,
  output logic   bus_oe_o
);
  phase_e ph_d;
  logic   oe_d, rd_d, wr_d, boe_d;

  always_comb begin
    ph_d  = phase_o;
    oe_d  = 1'b1;
    rd_d  = 1'b1;
    wr_d  = 1'b1;
    boe_d = 1'b0;
    unique case (phase_o)
      PH_RX_WAIT: begin
        if (!rx_avail_ni) begin
          ph_d = PH_RX_RUN;
          oe_d = 1'b0;
        end
      end
      PH_RX_RUN: begin
        if (rx_last_i) begin
          ph_d = PH_TURN_TX;
        end else if (rx_avail_ni) begin
          ph_d = PH_RX_WAIT;
        end else begin
          oe_d = 1'b0;
          rd_d = ~rx_room_i;
        end
      end
      PH_TURN_TX: begin
        ph_d  = PH_TX_RUN;
        boe_d = 1'b1;
      end
      PH_TX_RUN: begin
        if (tx_last_i) begin
          ph_d = PH_TURN_RX;
        end else begin
          boe_d = 1'b1;
          wr_d  = ~(hold_valid_nxt_i & ~tx_space_ni);
        end
      end
      PH_TURN_RX: ph_d = PH_RX_WAIT;
      default:    ph_d = PH_RX_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o  <= PH_RX_WAIT;
      oe_no    <= 1'b1;
      rd_no    <= 1'b1;
      wr_no    <= 1'b1;
      bus_oe_o <= 1'b0;
    end else begin
      phase_o  <= ph_d;
      oe_no    <= oe_d;
      rd_no    <= rd_d;
      wr_no    <= wr_d;
      bus_oe_o <= boe_d;
    end
  end
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
  import ufb_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 4096,
  parameter int unsigned RX_DEPTH = 2,
  parameter int unsigned DW = 8,
  localparam int unsigned CW = $clog2(FRAME_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_avail_ni,
  input  logic          tx_space_ni,
  output logic          out_en_no,
  output logic          rd_stb_no,
  output logic          wr_stb_no,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o
);
  phase_e        phase;
  logic [CW-1:0] rx_cnt, tx_cnt, ld_cnt;
  logic          capture, write, pop, load;
  logic          rx_room, rx_last, tx_last, ld_full;
  logic          hold_valid, hold_valid_nxt;

  // chip-side transfers happen only on edges where flag and strobe are both low
  assign capture = ~rx_avail_ni & ~rd_stb_no;
  assign write   = ~tx_space_ni & ~wr_stb_no;
  assign pop     = rx_valid_o & rx_ready_i;
  assign rx_last = capture & (rx_cnt == CW'(FRAME_BYTES - 1));
  assign tx_last = write & (tx_cnt == CW'(FRAME_BYTES - 1));
  assign ld_full = ld_cnt == CW'(FRAME_BYTES);

  assign tx_ready_o = (phase == PH_TX_RUN) & ~ld_full & (~hold_valid | write);
  assign load       = tx_valid_i & tx_ready_o;

  ufb_ctrl u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .rx_avail_ni      (rx_avail_ni),
    .tx_space_ni      (tx_space_ni),
    .rx_room_i        (rx_room),
    .rx_last_i        (rx_last),
    .tx_last_i        (tx_last),
    .hold_valid_nxt_i (hold_valid_nxt),
    .phase_o          (phase),
    .oe_no            (out_en_no),
    .rd_no            (rd_stb_no),
    .wr_no            (wr_stb_no),
    .bus_oe_o         (bus_oe_o)
  );

  ufb_rx_fifo #(.DEPTH(RX_DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (capture),
    .din_i   (bus_i),
    .pop_i   (pop),
    .dout_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .room_o  (rx_room)
  );

  ufb_tx_hold #(.DW(DW)) u_tx_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .din_i       (tx_data_i),
    .take_i      (write),
    .valid_o     (hold_valid),
    .valid_nxt_o (hold_valid_nxt),
    .dout_o      (bus_o)
  );

  ufb_counter #(.LIMIT(FRAME_BYTES)) u_rx_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (phase == PH_TURN_RX), .inc_i (capture), .cnt_o (rx_cnt)
  );

  ufb_counter #(.LIMIT(FRAME_BYTES)) u_tx_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (phase == PH_TURN_TX), .inc_i (write), .cnt_o (tx_cnt)
  );

  ufb_counter #(.LIMIT(FRAME_BYTES)) u_ld_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (phase == PH_TURN_TX), .inc_i (load), .cnt_o (ld_cnt)
  );
endmodule

// File: rtl/ufb_bridge_chk.sv
module ufb_bridge_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_avail_ni,
  input logic          tx_space_ni,
  input logic          out_en_no,
  input logic          rd_stb_no,
  input logic          wr_stb_no,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_valid_o,
  input logic          rx_ready_i
);
  a_r2_oe_leads_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_stb_no) |-> !$past(out_en_no));

  a_r5_wr_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_no |-> bus_oe_o);

  a_r6_wr_release_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_space_ni && !wr_stb_no) |=> (wr_stb_no && $stable(bus_o)));

  a_r8_stop_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_avail_ni && !out_en_no) |=> (out_en_no && rd_stb_no));

  a_r9_rx_stream_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  a_r10_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (out_en_no && rd_stb_no));

  a_r10_gap_into_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> $past(out_en_no));

  a_r10_gap_into_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_en_no) |-> !$past(bus_oe_o));
endmodule

bind usb_fifo_bridge ufb_bridge_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_usb_fifo_bridge.sv
module sim_usb_fifo_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 16;
  localparam int WAIT_LIMIT = 4000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       rx_avail_ni = 1'b1, tx_space_ni = 1'b1;
  logic       out_en_no, rd_stb_no, wr_stb_no, bus_oe_o;
  logic [7:0] bus_i = '0, bus_o, rx_data_o, tx_data_i = '0;
  logic       rx_valid_o, rx_ready_i = 1'b0, tx_valid_i = 1'b0, tx_ready_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit p_rx = 0, p_rdy = 0, p_tx = 0, p_vld = 0;
  int host_idx = 0, host_len = 0, rx_n = 0, tx_idx = 0, sink_n = 0;
  int first_wr_host = 0, last_wr_host = 0;
  logic [7:0] got  [256];
  logic [7:0] sink [256];
  int m_r2 = 0, m_r5 = 0, m_r6 = 0, m_r8 = 0, m_r9 = 0, m_r10 = 0;
  int h_r6 = 0, h_r8 = 0, h_r9 = 0;
  logic q_oe = 1, q_rd = 1, q_wr = 1, q_boe = 0, q_rxav = 1, q_txsp = 1;
  logic q_rv = 0, q_rr = 0;
  logic [7:0] q_bus = '0, q_rxd = '0;

  usb_fifo_bridge #(.FRAME_BYTES(FRAME), .RX_DEPTH(2), .DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_avail_ni(rx_avail_ni), .tx_space_ni(tx_space_ni),
    .out_en_no(out_en_no), .rd_stb_no(rd_stb_no), .wr_stb_no(wr_stb_no),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o)
  );

  function automatic logic [7:0] host_byte(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] tx_byte(input int k);
    return 8'(((k * 53 + 5) & 255) ^ 8'h5A);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  // stimulus toward the chip flags and local streams, changed away from the active edge
  initial forever begin
    @(negedge clk);
    cyc++;
    rx_avail_ni = !(host_idx < host_len) || (p_rx && (cyc % 5) >= 3);
    tx_space_ni = rst_ni && p_tx && (cyc % 6) >= 4;
    rx_ready_i  = rst_ni && !(p_rdy && (cyc % 7) < 3);
    tx_valid_i  = rst_ni && !(p_vld && (cyc % 3) == 0);
    tx_data_i   = tx_byte(tx_idx);
    bus_i       = host_byte(host_idx);
  end

  // chip and local-logic models plus protocol monitor
  always @(posedge clk) begin
    if (rst_ni) begin
      if (!rx_avail_ni && !rd_stb_no) host_idx <= host_idx + 1;
      if (rx_valid_o && rx_ready_i) begin
        got[rx_n & 255] <= rx_data_o;
        rx_n <= rx_n + 1;
      end
      if (!tx_space_ni && !wr_stb_no) begin
        sink[sink_n & 255] <= bus_o;
        sink_n <= sink_n + 1;
        if (sink_n % FRAME == 0) first_wr_host <= host_idx;
        if (sink_n % FRAME == FRAME - 1) last_wr_host <= host_idx;
      end
      if (tx_valid_i && tx_ready_o) tx_idx <= tx_idx + 1;
      if (!rd_stb_no && q_rd && q_oe) m_r2 <= m_r2 + 1;
      if (!wr_stb_no && !bus_oe_o) m_r5 <= m_r5 + 1;
      if (q_txsp && !q_wr) begin
        h_r6 <= h_r6 + 1;
        if (!wr_stb_no || bus_o != q_bus) m_r6 <= m_r6 + 1;
      end
      if (q_rxav && !q_oe) begin
        h_r8 <= h_r8 + 1;
        if (!out_en_no || !rd_stb_no) m_r8 <= m_r8 + 1;
      end
      if (q_rv && !q_rr) begin
        h_r9 <= h_r9 + 1;
        if (!rx_valid_o || rx_data_o != q_rxd) m_r9 <= m_r9 + 1;
      end
      if ((bus_oe_o && (!out_en_no || !rd_stb_no)) ||
          (bus_oe_o && !q_boe && !q_oe) || (!out_en_no && q_oe && q_boe))
        m_r10 <= m_r10 + 1;
      q_oe <= out_en_no; q_rd <= rd_stb_no; q_wr <= wr_stb_no; q_boe <= bus_oe_o;
      q_rxav <= rx_avail_ni; q_txsp <= tx_space_ni; q_rv <= rx_valid_o;
      q_rr <= rx_ready_i; q_bus <= bus_o; q_rxd <= rx_data_o;
    end
  end

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(out_en_no && rd_stb_no && wr_stb_no, "R1 strobes high", {out_en_no, rd_stb_no, wr_stb_no}, 7);
    check(!bus_oe_o, "R1 bus released", bus_oe_o, 0);
    check(!rx_valid_o && !tx_ready_o, "R1 streams idle", {rx_valid_o, tx_ready_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_no_data();
    int low = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!out_en_no || !rd_stb_no) low++;
    end
    check(low == 0, "R2 no read without data", low, 0);
  endtask

  task automatic t_frame(input int k, input bit prx, input bit prdy, input bit ptx, input bit pvld);
    int base = k * FRAME;
    int n = 0, bad = -1;
    p_rx = prx; p_rdy = prdy; p_tx = ptx; p_vld = pvld;
    host_len = base + FRAME + 3;
    while (sink_n < base + FRAME && n < WAIT_LIMIT) begin @(negedge clk); n++; end
    check(n < WAIT_LIMIT, "R7 watchdog on transmit", sink_n, base + FRAME);
    check(bus_oe_o == 0 && wr_stb_no && !tx_ready_o, "R7 transmit closed", {bus_oe_o, wr_stb_no, tx_ready_o}, 2);
    check(first_wr_host == base + FRAME, "R4 full frame before write", first_wr_host, base + FRAME);
    check(last_wr_host == base + FRAME, "R4 no reads during transmit", last_wr_host, base + FRAME);
    check(tx_idx == base + FRAME, "R7 exact result byte count", tx_idx, base + FRAME);
    n = 0;
    while (rx_n < base + FRAME && n < WAIT_LIMIT) begin @(negedge clk); n++; end
    check(n < WAIT_LIMIT, "R3 watchdog on receive", rx_n, base + FRAME);
    for (int i = base; i < base + FRAME; i++) if (bad < 0 && got[i & 255] != host_byte(i)) bad = i;
    check(bad < 0, "R3 receive order", (bad < 0) ? 0 : int'(got[bad & 255]), (bad < 0) ? 0 : int'(host_byte(bad)));
    bad = -1;
    for (int i = base; i < base + FRAME; i++) if (bad < 0 && sink[i & 255] != tx_byte(i)) bad = i;
    check(bad < 0, "R5 transmit order", (bad < 0) ? 0 : int'(sink[bad & 255]), (bad < 0) ? 0 : int'(tx_byte(bad)));
    check(m_r2 == 0, "R2 oe before rd", m_r2, 0);
    check(m_r5 == 0, "R5 write only with bus driven", m_r5, 0);
    check(m_r10 == 0, "R10 turnaround gap", m_r10, 0);
    check(m_r6 == 0, "R6 write pause hold", m_r6, 0);
    check(m_r8 == 0, "R8 read stop on empty", m_r8, 0);
    check(m_r9 == 0, "R9 consumer backpressure", m_r9, 0);
    if (ptx)  check(h_r6 > 0, "R6 pause exercised", h_r6, 1);
    if (prx)  check(h_r8 > 0, "R8 pause exercised", h_r8, 1);
    if (prdy) check(h_r9 > 0, "R9 stall exercised", h_r9, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_data();
    t_frame(0, 0, 0, 0, 0);
    t_frame(1, 1, 0, 0, 0);
    t_frame(2, 0, 1, 0, 0);
    t_frame(3, 0, 0, 1, 0);
    t_frame(4, 1, 1, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule